// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block is a slave-only control port on a two-wire serial bus. It gives an external bus master read and write access to a byte-wide register bank inside the chip. SCL and SDA are sampled on a fast system clock. The port detects start and stop conditions and answers one 7-bit device address. The upper four bits of that address are fixed at `0010`. The lower three bits come from strap pins.

The first byte of every write transaction is a pointer byte, and it selects the register. Its top bit says whether the pointer stays on one register or moves on after each data byte, so the master can move a block of registers in one transaction. The pointer and its flag are kept after the transaction ends. A master can therefore write only the pointer byte, stop, and then read from that register in a separate read transaction.

The port drives SDA only through an open-drain pull-down enable. The register bank sits outside the port and is reached through a plain interface: an address, write data, a one-cycle write strobe and combinational read data.

Top module: `i2cRegPort`

## Requirements
- R1: After reset, the port leaves SDA released (`sdaOe`=0), holds `regWe` low, and presents pointer 0 on `regAddr`.
- R2: The first byte after a start carries the device address in bits 7:1 and R/W in bit 0, where 1 means read. The port answers address `{0010, addrStrap}` with an acknowledge: it pulls SDA low during the ninth SCL pulse.
- R3: When the address does not match, the port leaves the acknowledge undriven. It then ignores every following byte (no register write, SDA released) until the next start or stop.
- R4: In a write transaction, the byte after the address is the pointer byte, and the port acknowledges it. Bits 5:0 select the register, bit 6 is ignored, and bit 7 is the auto-advance flag.
- R5: The port acknowledges each data byte after the pointer byte. For each one it gives a single-cycle `regWe` pulse, with `regWdata` equal to the byte and `regAddr` equal to the current pointer.
- R6: With the auto-advance flag at 0, the pointer stays on the same register for every data byte written or read.
- R7: With the auto-advance flag at 1, the pointer moves up by one after every data byte written or read, and it wraps from 63 to 0.
- R8: The pointer and its flag keep their values across a stop. A write transaction that carries only the pointer byte updates the pointer and produces no `regWe` pulse.
- R9: After an address with R/W=1, the port shifts out the register at the pointer, MSB first. With the flag at 1, the pointer also advances after the last byte read.
- R10: When the master does not acknowledge a read byte, the port releases SDA and drives nothing until the next start or stop.
- R11: A start is SDA falling while SCL is high, and it restarts address reception even without a stop before it (repeated start). A stop is SDA rising while SCL is high. `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addrStrap | input | 3 | Low three bits of the device address |
| regAddr | output | 6 | Register bank index (current pointer) |
| regWdata | output | 8 | Byte to write into the bank |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Bank contents at `regAddr` |

## Verification
A vector table sets up pointer bytes in four ways: flag clear, flag set, flag set at index 63, and bit 6 set. Each pair of writes is read back, ending either with a stop or with a repeated start. A fixed pointer leaves the second byte in one register, while an advancing pointer spreads the two bytes and wraps to entry 0. Directed cases cover:
- two kinds of wrong address, one differing in the strap bits and one in the fixed bits, checked for acknowledge and for the absence of any write;
- a pointer-only write followed by a read in a later transaction;
- a master refusal of a read byte, followed by idle clocks, which shows SDA is never driven;
- a later read, which shows that the pointer advanced past the refused byte.

// File: rtl/i2cPortPkg.sv
`timescale 1ns/1ps
package i2cPortPkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 3;
  localparam logic [3:0] DEV_HI = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } portState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeByte;
    logic advance;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/i2cLineSync.sv
`timescale 1ns/1ps
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclD;
  logic sdaD;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[i] <= 1'b1;
          sdaPipe[i] <= 1'b1;
        end else if (i == 0) begin
          sclPipe[i] <= sclIn;
          sdaPipe[i] <= sdaIn;
        end else begin
          sclPipe[i] <= sclPipe[(i == 0) ? 0 : i-1];
          sdaPipe[i] <= sdaPipe[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclS      = sclPipe[STAGES-1];
  assign sdaS      = sdaPipe[STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/i2cPortCtrl.sv
`timescale 1ns/1ps
module i2cPortCtrl
  import i2cPortPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaOe
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  portState_t state;
  logic [3:0] bitCnt;
  logic       ackNext;
  logic       readReq;
  logic       active;

  assign active = (state == ST_ADDR) || (state == ST_PTR) ||
                  (state == ST_WRITE) || (state == ST_READ);

  always_comb begin
    strobe = '0;
    if (!startSeen && !stopSeen && active) begin
      if (sclRise && bitCnt < ACK_SLOT) begin
        strobe.shiftIn = (state != ST_READ);
        if (bitCnt == LAST_BIT) begin
          strobe.loadPtr   = (state == ST_PTR);
          strobe.writeByte = (state == ST_WRITE);
          strobe.advance   = (state == ST_READ);
        end
      end
      if (sclRise && bitCnt == ACK_SLOT) begin
        strobe.loadTx = ((state == ST_ADDR) && readReq) ||
                        ((state == ST_READ) && !sdaS);
      end
      if (sclFall && bitCnt < ACK_SLOT && state == ST_READ) begin
        strobe.shiftTx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackNext <= 1'b0;
      readReq <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      ackNext <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (stopSeen) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackNext <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (active) begin
      if (sclRise) begin
        if (bitCnt == ACK_SLOT) begin
          bitCnt  <= '0;
          ackNext <= 1'b0;
          unique case (state)
            ST_ADDR:  state <= readReq ? ST_READ : ST_PTR;
            ST_PTR:   state <= ST_WRITE;
            ST_READ:  if (sdaS) state <= ST_SKIP;
            default:  state <= state;
          endcase
        end else begin
          bitCnt <= bitCnt + 4'd1;
          if (bitCnt == LAST_BIT) begin
            unique case (state)
              ST_ADDR: begin
                if (addrHit) begin
                  ackNext <= 1'b1;
                  readReq <= rwBit;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_PTR, ST_WRITE: ackNext <= 1'b1;
              default:          ackNext <= 1'b0;
            endcase
          end
        end
      end else if (sclFall) begin
        if (bitCnt == ACK_SLOT) begin
          sdaOe <= ackNext;
        end else if (state == ST_READ) begin
          sdaOe <= ~txBit;
        end else begin
          sdaOe <= 1'b0;
        end
      end
    end else begin
      sdaOe <= 1'b0;
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclS)); // R11
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R10
  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && state != ST_READ) |-> (bitCnt == ACK_SLOT)); // R2
endmodule

// File: rtl/i2cPortDatapath.sv
`timescale 1ns/1ps
module i2cPortDatapath
  import i2cPortPkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               sdaS,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [BYTE_W-1:0]  regRdata,
  output logic               addrHit,
  output logic               rwBit,
  output logic               txBit,
  output logic [PTR_W-1:0]   regAddr,
  output logic [BYTE_W-1:0]  regWdata,
  output logic               regWe
);
  localparam int FLAG_BIT = BYTE_W - 1;

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] byteNow;
  logic [PTR_W-1:0]  ptr;
  logic              incrFlag;

  assign byteNow = {rxShift[BYTE_W-2:0], sdaS};
  assign addrHit = (byteNow[BYTE_W-1:1] == {DEV_HI, addrStrap});
  assign rwBit   = byteNow[0];
  assign txBit   = txShift[BYTE_W-1];
  assign regAddr = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= byteNow;
      if (strobe.loadTx) begin
        txShift <= regRdata;
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      incrFlag <= 1'b0;
      regWe    <= 1'b0;
      regWdata <= '0;
    end else begin
      regWe <= strobe.writeByte;
      if (strobe.writeByte) regWdata <= byteNow;
      if (strobe.loadPtr) begin
        ptr      <= byteNow[PTR_W-1:0];
        incrFlag <= byteNow[FLAG_BIT];
      end else if ((regWe || strobe.advance) && incrFlag) begin
        ptr <= ptr + PTR_W'(1);
      end
    end
  end

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R5
  AST_PTR_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadPtr && !incrFlag) |=> $stable(ptr)); // R6
  AST_NO_WRITE_READING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> !regWe); // R9
endmodule

// File: rtl/i2cRegPort.sv
`timescale 1ns/1ps
module i2cRegPort
  import i2cPortPkg::*;
#(
  parameter int PTR_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] addrStrap,
  output logic [PTR_W-1:0]   regAddr,
  output logic [BYTE_W-1:0]  regWdata,
  output logic               regWe,
  input  logic [BYTE_W-1:0]  regRdata
);
  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  logic addrHit, rwBit, txBit;
  dpStrobe_t strobe;

  i2cLineSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2cPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaOe(sdaOe)
  );

  i2cPortDatapath #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaS(sdaS),
    .addrStrap(addrStrap), .regRdata(regRdata),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe)
  );
endmodule

// File: tb/i2cRegPort_bench.sv
`timescale 1ns/1ps
module i2cRegPort_bench;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b0010, STRAP};
  // {repeated start, pointer byte, data0, data1}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h85, 8'h3C, 8'hC3},
    {1'b1, 8'h0A, 8'h11, 8'h22},
    {1'b0, 8'hBF, 8'h9E, 8'h4D},
    {1'b1, 8'h4C, 8'h77, 8'h88},
    {1'b0, 8'hC1, 8'hF0, 8'h0F},
    {1'b1, 8'h80, 8'hAA, 8'h55}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaOe, regWe;
  logic [5:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] bank [64];
  logic [7:0] expBank [64];
  int checks = 0, fails = 0, weCount = 0, sdaRuleBad = 0;
  int lastWeAddr = 0, lastWeData = 0;
  int ptrM = 0;
  bit incrM = 1'b0;
  bit done = 1'b0;
  logic prevOe = 1'b0;

  always #4 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;
  assign regRdata = bank[regAddr];

  i2cRegPort u_i2cRegPort (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .addrStrap(STRAP), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) bank[i] <= 8'(i * 7 + 3);
    end else if (regWe) begin
      bank[regAddr] <= regWdata;
      weCount++;
      lastWeAddr = int'(regAddr);
      lastWeData = int'(regWdata);
    end
  end

  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclM) sdaRuleBad++;
    prevOe = sdaOe;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClk(Q); sclM = 1'b1; waitClk(2*Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ackd);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    ackd = ~sdaBus;
    waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); sclM = 1'b1; waitClk(Q);
      v[i] = sdaBus;
      waitClk(Q); sclM = 1'b0; waitClk(Q);
    end
    sendBit(~giveAck);
    sdaM = 1'b1;
  endtask

  task automatic wrTxn(input logic [6:0] dev, input logic [7:0] ptrB, input int nData,
                       input logic [7:0] d0, input logic [7:0] d1, input bit doStop);
    logic a;
    logic [7:0] d;
    int weBefore;
    bit hit;
    weBefore = weCount;
    hit = (dev == DEV);
    busStart();
    sendByte({dev, 1'b0}, a);
    check(a == hit, hit ? "R2" : "R3", int'(a), int'(hit));
    sendByte(ptrB, a);
    if (hit) begin
      check(a == 1'b1, "R4", int'(a), 1);
      ptrM = int'(ptrB[5:0]);
      incrM = ptrB[7];
    end else begin
      check(a == 1'b0, "R3", int'(a), 0);
    end
    for (int k = 0; k < nData; k++) begin
      d = (k == 0) ? d0 : d1;
      sendByte(d, a);
      if (hit) begin
        check(a == 1'b1, "R5", int'(a), 1);
        check(lastWeAddr == ptrM && lastWeData == int'(d), "R5",
              lastWeAddr * 256 + lastWeData, ptrM * 256 + int'(d));
        check(weCount == weBefore + k + 1, "R5", weCount, weBefore + k + 1);
        expBank[ptrM] = d;
        if (incrM) ptrM = (ptrM + 1) % 64;
      end else begin
        check(a == 1'b0, "R3", int'(a), 0);
      end
    end
    if (!hit) check(weCount == weBefore, "R3", weCount, weBefore);
    if (hit && nData == 0) check(weCount == weBefore, "R8", weCount, weBefore);
    if (doStop) busStop();
  endtask

  task automatic rdTxn(input int n, input string req, input bit doStop);
    logic a;
    logic [7:0] v;
    busStart();
    sendByte({DEV, 1'b1}, a);
    check(a == 1'b1, "R2", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, v);
      check(v == expBank[ptrM], req, int'(v), int'(expBank[ptrM]));
      if (incrM) ptrM = (ptrM + 1) % 64;
    end
    if (doStop) busStop();
  endtask

  initial begin
    waitClk(150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    int lows;
    for (int i = 0; i < 64; i++) expBank[i] = 8'(i * 7 + 3);
    waitClk(10);
    rstN = 1'b1;
    waitClk(5);
    check(sdaOe == 1'b0, "R1", int'(sdaOe), 0);
    check(regWe == 1'b0, "R1", int'(regWe), 0);
    check(regAddr == 6'd0, "R1", int'(regAddr), 0);

    for (int v = 0; v < 6; v++) begin
      bit rep;
      string req;
      rep = VEC[v][24];
      req = VEC[v][23] ? "R7" : "R6";
      wrTxn(DEV, VEC[v][23:16], 2, VEC[v][15:8], VEC[v][7:0], !rep);
      wrTxn(DEV, VEC[v][23:16], 0, 8'h00, 8'h00, !rep);
      rdTxn(2, rep ? "R11" : req, 1'b1);
    end

    // R3: wrong strap bits, then wrong fixed bits
    wrTxn(7'h13, 8'h82, 2, 8'hEE, 8'hDD, 1'b1);
    wrTxn(7'h55, 8'h82, 2, 8'hEE, 8'hDD, 1'b1);
    rdTxn(1, "R3", 1'b1);

    // R8: pointer-only write, read in a later transaction
    wrTxn(DEV, 8'h87, 0, 8'h00, 8'h00, 1'b1);
    waitClk(20);
    rdTxn(3, "R8", 1'b1);

    // R6: fixed pointer over several reads
    wrTxn(DEV, 8'h05, 0, 8'h00, 8'h00, 1'b1);
    rdTxn(3, "R6", 1'b1);

    // R10: master refuses a read byte, then idle clocks
    wrTxn(DEV, 8'h90, 0, 8'h00, 8'h00, 1'b1);
    rdTxn(1, "R9", 1'b0);
    lows = 0;
    sdaM = 1'b1;
    for (int i = 0; i < 9; i++) begin
      waitClk(Q); sclM = 1'b1; waitClk(Q);
      if (!sdaBus) lows++;
      waitClk(Q); sclM = 1'b0; waitClk(Q);
    end
    check(lows == 0, "R10", lows, 0);
    busStop();
    // R9: pointer advanced past the refused byte
    rdTxn(1, "R9", 1'b1);

    check(sdaRuleBad == 0, "R11", sdaRuleBad, 0);
    done = 1'b1;
    summary();
  end
endmodule